// File: doc/BRIEF.md
# Guarded Interrupt Vector Relocation Register

This block is an 8-bit control register for a small microcontroller. It decides where the reset entry point and the interrupt vector table sit in program memory. Software writes the register through a one-cycle write strobe, and the current contents are always visible on a read bus. Bit 4 holds a pull-up disable flag, which is passed straight out to port logic. Bit 1 selects the vector table location. Bit 0 is an unlock bit that opens a short window. The vector select bit can change only while that window is open.

Software relocates the table in two steps. It first writes the unlock bit to one. It then writes the wanted select value, with the unlock bit at zero, before the window expires. From the moment the unlock bit sets, the block drives an interrupt-block output that keeps the core from taking interrupts. The block does not store or alter the core's global interrupt enable; the blocking acts only through that output. Blocking ends in one of two ways. If the window runs out without a select write, it ends together with the window. After a successful select write, it ends once the core signals that the following instruction has completed.

The reset address and the vector base are computed combinationally. They depend on a boot-reset configuration input, a boot-section start address input and the select bit.

Top module: `vec_reloc_reg`

## Requirements
- R1: The read bus returns {3'b000, pull-up disable, 2'b00, vector select, unlock} (bits 7..0). Bits 7..5 and 3..2 always read zero, whatever is written to them.
- R2: After reset all register bits read zero and the interrupt-block output is low.
- R3: Any write loads bit 4 of the write data into pull-up disable, whether or not the window is open.
- R4: A write with bit 0 set makes the unlock bit and the interrupt-block output read one from the cycle after the write edge.
- R5: A write with bit 0 clear, taken at an edge where the unlock bit reads one, loads bit 1 into vector select and clears the unlock bit. This includes the fourth cycle of the window.
- R6: A write taken while the unlock bit reads zero leaves vector select unchanged. This includes a write one cycle after the window has expired.
- R7: If no select write arrives, the unlock bit and the interrupt-block output stay high for exactly 4 cycles and then both clear.
- R8: After a successful select write, the interrupt-block output stays high until an edge samples the instruction-done strobe high. It is low from the following cycle.
- R9: Writing bit 0 as one again while the window is open restarts the 4-cycle count and leaves vector select unchanged.
- R10: The reset address is 0 when the boot-reset configuration input is 1, and equals the boot-section start address when that input is 0.
- R11: The vector base is 1 when vector select is 0, and the boot-section start address plus 1 when it is 1. This does not depend on the boot-reset configuration input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Register read value |
| instrDone | input | 1 | Strobe marking completion of an instruction |
| bootRstCfg | input | 1 | Boot-reset configuration, 1 = unprogrammed |
| bootStart | input | ADDR_W | Boot-section start address |
| pullUpDis | output | 1 | Pull-up disable flag |
| irqBlock | output | 1 | Interrupt acceptance block |
| resetAddr | output | ADDR_W | Reset entry address |
| vecBase | output | ADDR_W | Interrupt vector table base |

## Verification
Register effects, covering the read bus, the unlock bit and the interrupt-block output, are due one cycle after the edge that samples a write. The bench drives inputs at falling edges and reads results at the next falling edge, half a cycle after the edge that updates them. Window timing is counted edge by edge from the unlock write. The bench checks the unlock bit at each of the four following samples and expects it to clear at the fifth. The select write is placed exactly at the fourth and at the fifth edge to probe both window boundaries. The address outputs are combinational, so they are checked in the same sample as the register or input change that drives them.

// File: rtl/vec_reloc_pkg.sv
package vec_reloc_pkg;
  typedef struct packed {
    logic loadPud;
    logic loadSel;
  } regStrobes_t;
  localparam int PUD_BIT = 4;
  localparam int SEL_BIT = 1;
  localparam int UNLOCK_BIT = 0;
endpackage

// File: rtl/vec_reloc_ctrl.sv
module vec_reloc_ctrl
  import vec_reloc_pkg::*;
#(
  parameter int WIN_CYC = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        wrUnlock,
  input  logic        instrDone,
  output regStrobes_t strobes,
  output logic        unlockQ,
  output logic        irqBlock
);
  localparam int CNT_W = $clog2(WIN_CYC + 1);

  logic [CNT_W-1:0] winCnt;
  logic waitInstr;
  logic setUnlock;

  assign setUnlock       = wrEn & wrUnlock;
  assign strobes.loadPud = wrEn;
  assign strobes.loadSel = wrEn & unlockQ & ~wrUnlock;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      unlockQ <= 1'b0;
      winCnt  <= '0;
    end else if (setUnlock) begin
      unlockQ <= 1'b1;
      winCnt  <= CNT_W'(WIN_CYC);
    end else if (strobes.loadSel) begin
      unlockQ <= 1'b0;
      winCnt  <= '0;
    end else if (unlockQ) begin
      if (winCnt == CNT_W'(1)) begin
        unlockQ <= 1'b0;
        winCnt  <= '0;
      end else begin
        winCnt <= winCnt - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                waitInstr <= 1'b0;
    else if (strobes.loadSel) waitInstr <= 1'b1;
    else if (instrDone)       waitInstr <= 1'b0;
  end

  assign irqBlock = unlockQ | waitInstr;
endmodule

// File: rtl/vec_reloc_datapath.sv
module vec_reloc_datapath
  import vec_reloc_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobes_t       strobes,
  input  logic [7:0]        wrData,
  input  logic              unlockQ,
  input  logic              bootRstCfg,
  input  logic [ADDR_W-1:0] bootStart,
  output logic [7:0]        rdData,
  output logic              pullUpDis,
  output logic [ADDR_W-1:0] resetAddr,
  output logic [ADDR_W-1:0] vecBase
);
  logic vecSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pullUpDis <= 1'b0;
      vecSel    <= 1'b0;
    end else begin
      if (strobes.loadPud) pullUpDis <= wrData[PUD_BIT];
      if (strobes.loadSel) vecSel    <= wrData[SEL_BIT];
    end
  end

  always_comb begin
    rdData             = '0;
    rdData[PUD_BIT]    = pullUpDis;
    rdData[SEL_BIT]    = vecSel;
    rdData[UNLOCK_BIT] = unlockQ;
  end

  assign resetAddr = bootRstCfg ? '0 : bootStart;
  assign vecBase   = vecSel ? bootStart + ADDR_W'(1) : ADDR_W'(1);
endmodule

// File: rtl/vec_reloc_reg.sv
module vec_reloc_reg
  import vec_reloc_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int WIN_CYC = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  input  logic              instrDone,
  input  logic              bootRstCfg,
  input  logic [ADDR_W-1:0] bootStart,
  output logic              pullUpDis,
  output logic              irqBlock,
  output logic [ADDR_W-1:0] resetAddr,
  output logic [ADDR_W-1:0] vecBase
);
  regStrobes_t strobes;
  logic unlockQ;

  vec_reloc_ctrl #(.WIN_CYC(WIN_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrUnlock(wrData[UNLOCK_BIT]),
    .instrDone(instrDone), .strobes(strobes), .unlockQ(unlockQ),
    .irqBlock(irqBlock)
  );

  vec_reloc_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .unlockQ(unlockQ), .bootRstCfg(bootRstCfg), .bootStart(bootStart),
    .rdData(rdData), .pullUpDis(pullUpDis), .resetAddr(resetAddr),
    .vecBase(vecBase)
  );
endmodule

// File: rtl/vec_reloc_reg_chk.sv
module vec_reloc_reg_chk #(
  parameter int ADDR_W  = 16,
  parameter int WIN_CYC = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [7:0]        wrData,
  input logic [7:0]        rdData,
  input logic              irqBlock,
  input logic              bootRstCfg,
  input logic [ADDR_W-1:0] bootStart,
  input logic [ADDR_W-1:0] resetAddr,
  input logic [ADDR_W-1:0] vecBase
);
  localparam int RUN_W = $clog2(WIN_CYC + 2) + 1;
  logic [RUN_W-1:0] runLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  runLen <= '0;
    else if (wrEn && wrData[0]) runLen <= RUN_W'(1);
    else if (rdData[0])         runLen <= runLen + RUN_W'(1);
    else                        runLen <= '0;
  end

  // R1
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdData & 8'hEC) == 8'h00);
  // R4
  unlock_sets_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[0]) |=> (rdData[0] && irqBlock));
  // R6
  sel_locked_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdData[0] |=> $stable(rdData[1]));
  // R7
  window_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdData[0] |-> (runLen <= RUN_W'(WIN_CYC)));
  // R4
  unlock_implies_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdData[0] |-> irqBlock);
  // R10
  reset_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    bootRstCfg |-> (resetAddr == '0));
  // R11
  vec_base_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdData[1] |-> (vecBase == ADDR_W'(1)));
endmodule

bind vec_reloc_reg vec_reloc_reg_chk #(.ADDR_W(ADDR_W), .WIN_CYC(WIN_CYC)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
  .irqBlock(irqBlock), .bootRstCfg(bootRstCfg), .bootStart(bootStart),
  .resetAddr(resetAddr), .vecBase(vecBase)
);

// File: tb/vec_reloc_reg_bench.sv
module vec_reloc_reg_bench;
  localparam int AW = 16;
  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0, instrDone = 1'b0, bootRstCfg = 1'b1;
  logic [7:0] wrData = '0;
  logic [AW-1:0] bootStart = 16'h7C00;
  logic [7:0] rdData;
  logic pullUpDis, irqBlock;
  logic [AW-1:0] resetAddr, vecBase;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  vec_reloc_reg u_vec_reloc_reg (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .instrDone(instrDone), .bootRstCfg(bootRstCfg), .bootStart(bootStart),
    .pullUpDis(pullUpDis), .irqBlock(irqBlock), .resetAddr(resetAddr),
    .vecBase(vecBase)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wrReg(logic [7:0] d);
    wrEn = 1'b1; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finishWait();
    instrDone = 1'b1; @(negedge clk); instrDone = 1'b0;
  endtask

  task automatic testReset();
    chk("R2 rd", rdData, 8'h00);
    chk("R2 block", irqBlock, 1'b0);
  endtask

  task automatic testReservedAndPud();
    wrReg(8'hFE);
    chk("R1 reserved", rdData, 8'h10);
    chk("R3 pud set", pullUpDis, 1'b1);
    chk("R6 sel locked", rdData[1], 1'b0);
    wrReg(8'h00);
    chk("R3 pud clr", pullUpDis, 1'b0);
  endtask

  task automatic testNoSelWrite();
    wrReg(8'h01);
    chk("R4 unlock", rdData[0], 1'b1);
    chk("R4 block", irqBlock, 1'b1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R7 window held", {rdData[0], irqBlock}, 2'b11);
    end
    @(negedge clk);
    chk("R7 window closed", {rdData[0], irqBlock}, 2'b00);
  endtask

  task automatic testSelLastSlot();
    wrReg(8'h01);
    idle(3);
    wrReg(8'h12);
    chk("R5 sel loaded", rdData, 8'h12);
    chk("R8 block held", irqBlock, 1'b1);
    idle(6);
    chk("R8 block waits", irqBlock, 1'b1);
    finishWait();
    chk("R8 block released", irqBlock, 1'b0);
    chk("R11 vecBase boot", vecBase, 16'h7C01);
    chk("R10 resetAddr unprog", resetAddr, 16'h0000);
    bootRstCfg = 1'b0; #1;
    chk("R10 resetAddr prog", resetAddr, 16'h7C00);
    chk("R11 vecBase indep", vecBase, 16'h7C01);
    bootRstCfg = 1'b1;
  endtask

  task automatic testLateWrite();
    wrReg(8'h01);
    idle(4);
    wrReg(8'h00);
    chk("R6 late ignored", rdData[1], 1'b1);
    wrReg(8'h00);
    chk("R6 locked again", rdData[1], 1'b1);
  endtask

  task automatic testRestart();
    wrReg(8'h01);
    idle(2);
    wrReg(8'h01);
    chk("R9 sel kept", rdData[1], 1'b1);
    idle(3);
    chk("R9 window restarted", rdData[0], 1'b1);
    wrReg(8'h00);
    chk("R9 sel after restart", rdData[1], 1'b0);
    chk("R11 vecBase app", vecBase, 16'h0001);
    finishWait();
    chk("R8 released", irqBlock, 1'b0);
  endtask

  initial begin
    idle(2);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testReservedAndPud();
    testNoSelWrite();
    testSelLastSlot();
    testLateWrite();
    testRestart();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule